// File: doc/BRIEF.md
# Interpolating Base-2 Antilogarithm Unit

This block turns a fixed-point value M into an approximate 2^M without a multiplier. The upper bits of M are an integer exponent and pass straight to the output. The lower 13 bits are a fraction f. For that fraction the unit computes 2^f − 1, the part below the leading one, so the caller gets the result as exponent plus mantissa. This is the form a logarithmic-number or floating-point datapath expects.

The mantissa starts from the straight-line estimate 1 + f. A table holds the gap between that line and the true curve, sampled 64 times across [0,1]. The top six fraction bits choose the two samples that enclose f, and the low seven bits set how far f sits between them. The gap at f is the lower sample plus a fraction of the difference between the two samples. That product is formed by adding the base-2 logarithms of the difference and of the offset. Each logarithm comes from a leading-one detector and a small log table, and the sum goes back through an antilog table and a shifter. A comparison of the two samples decides whether the product is added or subtracted. Requests carry a valid strobe, and results come out a fixed number of cycles later. An optional register halfway through sets that number.

Top module: `antilog_interp_unit`

## Requirements
- R1: `outExp` of a result equals bits [20:13] of `inM` of the request that produced it.
- R2: With the default mid-pipeline register, `outValid` is high exactly two cycles after each cycle with `inValid` high, and low in every other cycle.
- R3: When bits [6:0] of `inM` are zero, take f = `inM[12:0]` and i = f[12:7]. Let C(i) = round(65536·(1 + i/64 − 2^(i/64))). Then `outMant` equals floor((8·f − C(i)) / 8) exactly.
- R4: For every fraction f = `inM[12:0]`, `outMant` lies within 2 of 8192·(2^(f/8192) − 1).
- R5: In cycles where `outValid` is low, `outExp` and `outMant` keep the values of the last result.
- R6: While reset is held, `outValid`, `outExp` and `outMant` are all zero.
- R7: A new request is accepted in every cycle, and results appear one per cycle in request order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Request strobe for `inM` |
| inM | input | 21 | Operand: integer part [20:13], fraction [12:0] |
| outValid | output | 1 | Result strobe |
| outExp | output | 8 | Integer part of the result's request |
| outMant | output | 13 | Fraction of 2^f, i.e. 2^f − 1 in units of 2^-13 |

## Verification
Over most of the range, the two enclosing samples rise together, so the interpolation adds. Beyond the peak of the gap curve (segment 34 and up) they fall, and the interpolation subtracts. The last segment brackets against the endpoint sample, which is zero. Both the subtract path and that endpoint are reached only through specific fraction values. For this reason the stimulus sweeps all 8192 fractions back to back, so every segment is hit at every offset with changing exponents. A second phase sends pseudo-random operands with random gaps between them, which exercises holding the outputs and the latency timing between requests.

// File: rtl/antilog_pkg.sv
package antilog_pkg;

  // Strobes from control to datapath: load mid stage, load output stage.
  typedef struct packed {
    logic capMid;
    logic capOut;
  } antiStrobe_t;

  // Gap between the line 1+x and 2^x at x = k/2^idxW, scaled by 2^fw.
  function automatic int gapSample(input int k, input int idxW, input int fw);
    real x;
    real v;
    x = real'(k) / (2.0 ** idxW);
    v = (1.0 + x) - $pow(2.0, x);
    return $rtoi(v * (2.0 ** fw) + 0.5);
  endfunction

  // log2(1 + k/2^idxW) scaled by 2^fw.
  function automatic int logSample(input int k, input int idxW, input int fw);
    real x;
    real v;
    x = real'(k) / (2.0 ** idxW);
    v = $ln(1.0 + x) / $ln(2.0);
    return $rtoi(v * (2.0 ** fw) + 0.5);
  endfunction

  // 2^(k/2^idxW) scaled by 2^fw.
  function automatic int powSample(input int k, input int idxW, input int fw);
    real x;
    real v;
    x = real'(k) / (2.0 ** idxW);
    v = $pow(2.0, x);
    return $rtoi(v * (2.0 ** fw) + 0.5);
  endfunction

endpackage

// File: rtl/antilog_lod.sv
// Leading-one detector with normalisation: reports the position of the top
// set bit and the bits beneath it, left aligned into a field of FLD_W bits.
module antilog_lod #(
  parameter int IN_W  = 13,
  parameter int FLD_W = 8,
  parameter int POS_W = $clog2(IN_W)
) (
  input  logic [IN_W-1:0]  vec,
  output logic [POS_W-1:0] pos,
  output logic [FLD_W-1:0] fld,
  output logic             isZero
);

  logic [IN_W-1:0] normVec;

  always_comb begin
    pos = '0;
    for (int b = 0; b < IN_W; b++) begin
      if (vec[b]) pos = POS_W'(b);
    end
  end

  assign isZero  = (vec == '0);
  assign normVec = vec << (POS_W'(IN_W - 1) - pos);

  if (IN_W - 1 >= FLD_W) begin : g_trim
    assign fld = FLD_W'(normVec >> (IN_W - 1 - FLD_W));
  end else begin : g_pad
    assign fld = FLD_W'({normVec, {(FLD_W - IN_W + 1){1'b0}}});
  end

endmodule

// File: rtl/antilog_tables.sv
// Constant tables filled at elaboration: the gap curve (2^IDX_W + 1 points,
// read at two adjacent points), the log table (read twice) and the antilog table.
module antilog_tables
  import antilog_pkg::*;
#(
  parameter int IDX_W   = 6,
  parameter int ENT_W   = 13,
  parameter int TAB_FW  = 16,
  parameter int LOG_IW  = 8,
  parameter int LOG_FW  = 12,
  parameter int ANTI_IW = 8,
  parameter int ANTI_FW = 14
) (
  input  logic [IDX_W-1:0]   segIdx,
  output logic [ENT_W-1:0]   lowSample,
  output logic [ENT_W-1:0]   highSample,
  input  logic [LOG_IW-1:0]  logIdxD,
  input  logic [LOG_IW-1:0]  logIdxO,
  output logic [LOG_FW-1:0]  logValD,
  output logic [LOG_FW-1:0]  logValO,
  input  logic [ANTI_IW-1:0] antiIdx,
  output logic [ANTI_FW:0]   antiVal
);

  localparam int SEGS   = 1 << IDX_W;
  localparam int LOG_N  = 1 << LOG_IW;
  localparam int ANTI_N = 1 << ANTI_IW;

  logic [ENT_W-1:0]  gapRom  [SEGS+1];
  logic [LOG_FW-1:0] logRom  [LOG_N];
  logic [ANTI_FW:0]  antiRom [ANTI_N];
  logic [IDX_W:0]    lowIdx;
  logic [IDX_W:0]    highIdx;

  for (genvar k = 0; k <= SEGS; k++) begin : g_gap
    assign gapRom[k] = ENT_W'(gapSample(k, IDX_W, TAB_FW));
  end

  for (genvar k = 0; k < LOG_N; k++) begin : g_log
    assign logRom[k] = LOG_FW'(logSample(k, LOG_IW, LOG_FW));
  end

  for (genvar k = 0; k < ANTI_N; k++) begin : g_anti
    assign antiRom[k] = (ANTI_FW + 1)'(powSample(k, ANTI_IW, ANTI_FW));
  end

  assign lowIdx     = {1'b0, segIdx};
  assign highIdx    = lowIdx + (IDX_W + 1)'(1);
  assign lowSample  = gapRom[lowIdx];
  assign highSample = gapRom[highIdx];
  assign logValD    = logRom[logIdxD];
  assign logValO    = logRom[logIdxO];
  assign antiVal    = antiRom[antiIdx];

endmodule

// File: rtl/antilog_ctrl.sv
// Valid tracking for the one- or two-stage pipeline.
module antilog_ctrl
  import antilog_pkg::*;
#(
  parameter int REG_MID = 1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  output antiStrobe_t ctl,
  output logic        outValid
);

  if (REG_MID != 0) begin : g_twoStage
    logic midValid;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) midValid <= 1'b0;
      else       midValid <= inValid;
    end
    assign ctl.capMid = inValid;
    assign ctl.capOut = midValid;
  end else begin : g_oneStage
    assign ctl.capMid = 1'b0;
    assign ctl.capOut = inValid;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= ctl.capOut;
  end

endmodule

// File: rtl/antilog_datapath.sv
// Stage A: table reads, leading-one detection and log sum.
// Stage B: antilog, scaling shift, add/subtract and mantissa formation.
module antilog_datapath
  import antilog_pkg::*;
#(
  parameter int EXP_W   = 8,
  parameter int IDX_W   = 6,
  parameter int OFF_W   = 7,
  parameter int TAB_FW  = 16,
  parameter int LOG_IW  = 8,
  parameter int LOG_FW  = 12,
  parameter int ANTI_IW = 8,
  parameter int ANTI_FW = 14,
  parameter int MANT_W  = 13,
  parameter int REG_MID = 1
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  antiStrobe_t                     ctl,
  input  logic [EXP_W+IDX_W+OFF_W-1:0]    inM,
  output logic [EXP_W-1:0]                outExp,
  output logic [MANT_W-1:0]               outMant
);

  localparam int FRAC_W = IDX_W + OFF_W;
  localparam int M_W    = EXP_W + FRAC_W;
  localparam int ENT_W  = TAB_FW - 3;
  localparam int DIFF_W = ENT_W;
  localparam int POSD_W = $clog2(DIFF_W);
  localparam int POSO_W = $clog2(OFF_W);
  localparam int P_MAX  = DIFF_W + OFF_W - 1;
  localparam int SUM_IW = $clog2(P_MAX + 1);
  localparam int SUM_W  = SUM_IW + LOG_FW;
  localparam int PROD_W = ANTI_FW + 1 + P_MAX;

  // ---------------- stage A ----------------
  logic [EXP_W-1:0]  expA;
  logic [FRAC_W-1:0] fracA;
  logic [IDX_W-1:0]  segA;
  logic [OFF_W-1:0]  offA;
  logic [ENT_W-1:0]  lowA, highA;
  logic              riseA;
  logic [DIFF_W-1:0] diffA;
  logic [POSD_W-1:0] posD;
  logic [POSO_W-1:0] posO;
  logic [LOG_IW-1:0] fldD, fldO;
  logic              zeroD, zeroO;
  logic [LOG_FW-1:0] logD, logO;
  logic [SUM_W-1:0]  sumA;

  assign expA  = inM[M_W-1 -: EXP_W];
  assign fracA = inM[FRAC_W-1:0];
  assign segA  = inM[FRAC_W-1 -: IDX_W];
  assign offA  = inM[OFF_W-1:0];
  assign riseA = highA > lowA;
  assign diffA = riseA ? (highA - lowA) : (lowA - highA);

  antilog_lod #(.IN_W(DIFF_W), .FLD_W(LOG_IW), .POS_W(POSD_W)) u_lodDiff (
    .vec(diffA), .pos(posD), .fld(fldD), .isZero(zeroD)
  );

  antilog_lod #(.IN_W(OFF_W), .FLD_W(LOG_IW), .POS_W(POSO_W)) u_lodOff (
    .vec(offA), .pos(posO), .fld(fldO), .isZero(zeroO)
  );

  logic [ANTI_IW-1:0] antiIdx;
  logic [ANTI_FW:0]   antiVal;

  antilog_tables #(
    .IDX_W(IDX_W), .ENT_W(ENT_W), .TAB_FW(TAB_FW), .LOG_IW(LOG_IW),
    .LOG_FW(LOG_FW), .ANTI_IW(ANTI_IW), .ANTI_FW(ANTI_FW)
  ) u_tables (
    .segIdx(segA), .lowSample(lowA), .highSample(highA),
    .logIdxD(fldD), .logIdxO(fldO), .logValD(logD), .logValO(logO),
    .antiIdx(antiIdx), .antiVal(antiVal)
  );

  // Fixed-point log2(diff) + log2(offset): integer position, table fraction.
  assign sumA = SUM_W'({posD, logD}) + SUM_W'({posO, logO});

  // ---------------- mid boundary ----------------
  logic [EXP_W-1:0]  midExp;
  logic [FRAC_W-1:0] midFrac;
  logic [ENT_W-1:0]  midLow, midHigh;
  logic [SUM_W-1:0]  midSum;
  logic              midZero;

  if (REG_MID != 0) begin : g_midReg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        midExp  <= '0;
        midFrac <= '0;
        midLow  <= '0;
        midHigh <= '0;
        midSum  <= '0;
        midZero <= 1'b1;
      end else if (ctl.capMid) begin
        midExp  <= expA;
        midFrac <= fracA;
        midLow  <= lowA;
        midHigh <= highA;
        midSum  <= sumA;
        midZero <= zeroD | zeroO;
      end
    end
  end else begin : g_midWire
    always_comb begin
      midExp  = expA;
      midFrac = fracA;
      midLow  = lowA;
      midHigh = highA;
      midSum  = sumA;
      midZero = zeroD | zeroO;
    end
  end

  // ---------------- stage B ----------------
  logic [SUM_IW-1:0] shiftP;
  logic [PROD_W-1:0] prod;
  logic [DIFF_W-1:0] term;
  logic              riseB;
  logic [ENT_W-1:0]  cInterp;
  logic [TAB_FW-1:0] m16, extC, fixB;
  logic [MANT_W-1:0] mantB;

  assign shiftP  = SUM_IW'(midSum >> LOG_FW);
  assign antiIdx = ANTI_IW'(midSum[LOG_FW-1:0] >> (LOG_FW - ANTI_IW));
  assign prod    = PROD_W'(antiVal) << shiftP;
  assign term    = midZero ? '0 : DIFF_W'(prod >> (ANTI_FW + OFF_W));
  assign riseB   = midHigh > midLow;
  assign cInterp = riseB ? (midLow + term) : (midLow - term);
  assign m16     = TAB_FW'(midFrac) << (TAB_FW - FRAC_W);
  assign extC    = TAB_FW'(cInterp);
  assign fixB    = (extC > m16) ? '0 : (m16 - extC);
  assign mantB   = MANT_W'(fixB >> (TAB_FW - MANT_W));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outExp  <= '0;
      outMant <= '0;
    end else if (ctl.capOut) begin
      outExp  <= midExp;
      outMant <= mantB;
    end
  end

  // Interpolated gap must stay between the two bracketing samples.
  logic [ENT_W-1:0] segMin, segMax;
  assign segMin = riseB ? midLow : midHigh;
  assign segMax = riseB ? midHigh : midLow;

  AST_SEG_BRACKET: assert property (@(posedge clk) disable iff (!rstN) ctl.capOut |-> ((cInterp >= segMin) && (cInterp <= segMax))); // R4
  AST_MANT_BELOW_FRAC: assert property (@(posedge clk) disable iff (!rstN) ctl.capOut |-> (mantB <= MANT_W'(m16 >> (TAB_FW - MANT_W)))); // R4

endmodule

// File: rtl/antilog_interp_unit.sv
module antilog_interp_unit
  import antilog_pkg::*;
#(
  parameter int EXP_W   = 8,
  parameter int IDX_W   = 6,
  parameter int OFF_W   = 7,
  parameter int TAB_FW  = 16,
  parameter int LOG_IW  = 8,
  parameter int LOG_FW  = 12,
  parameter int ANTI_IW = 8,
  parameter int ANTI_FW = 14,
  parameter int MANT_W  = 13,
  parameter int REG_MID = 1
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         inValid,
  input  logic [EXP_W+IDX_W+OFF_W-1:0] inM,
  output logic                         outValid,
  output logic [EXP_W-1:0]             outExp,
  output logic [MANT_W-1:0]            outMant
);

  localparam int FRAC_W = IDX_W + OFF_W;
  localparam int M_W    = EXP_W + FRAC_W;
  localparam int LAT    = (REG_MID != 0) ? 2 : 1;

  antiStrobe_t ctl;

  antilog_ctrl #(.REG_MID(REG_MID)) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .ctl(ctl), .outValid(outValid)
  );

  antilog_datapath #(
    .EXP_W(EXP_W), .IDX_W(IDX_W), .OFF_W(OFF_W), .TAB_FW(TAB_FW),
    .LOG_IW(LOG_IW), .LOG_FW(LOG_FW), .ANTI_IW(ANTI_IW), .ANTI_FW(ANTI_FW),
    .MANT_W(MANT_W), .REG_MID(REG_MID)
  ) u_datapath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .inM(inM),
    .outExp(outExp), .outMant(outMant)
  );

  // Cycles since reset, so history checks never reach into reset.
  logic [1:0] sinceRst;
  logic       warm;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  sinceRst <= '0;
    else if (sinceRst != 2'd3)  sinceRst <= sinceRst + 2'd1;
  end
  assign warm = sinceRst >= 2'(LAT);

  AST_EXP_PASS: assert property (@(posedge clk) disable iff (!rstN) (warm && outValid) |-> (outExp == $past(inM[M_W-1 -: EXP_W], LAT))); // R1
  AST_OUT_LATENCY: assert property (@(posedge clk) disable iff (!rstN) warm |-> (outValid == $past(inValid, LAT))); // R2
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rstN) !outValid |-> ($stable(outExp) && $stable(outMant))); // R5

endmodule

// File: tb/antilog_interp_unit_bench.sv
`timescale 1ns/1ps
module antilog_interp_unit_bench;

  localparam int EXP_W  = 8;
  localparam int FRAC_W = 13;
  localparam int MANT_W = 13;
  localparam int LAT    = 2;

  logic                     clk = 1'b0;
  logic                     rstN = 1'b0;
  logic                     inValid = 1'b0;
  logic [EXP_W+FRAC_W-1:0]  inM = '0;
  logic                     outValid;
  logic [EXP_W-1:0]         outExp;
  logic [MANT_W-1:0]        outMant;

  always #5 clk = ~clk;

  antilog_interp_unit u_antilog_interp_unit (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inM(inM),
    .outValid(outValid), .outExp(outExp), .outMant(outMant)
  );

  typedef struct { int due; int expV; int frac; } pend_t;
  pend_t pendQ[$];

  int negCount = 0;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit monitorOn = 1'b0;
  int lastExp = 0;
  int lastMant = 0;

  task automatic report(input bit ok, input string req, input string what,
                        input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  // Exact value when the offset bits are zero (R3).
  function automatic int exactMant(input int f);
    int  i;
    int  c;
    real x;
    i = f >> 7;
    x = real'(i) / 64.0;
    c = $rtoi(((1.0 + x) - $pow(2.0, x)) * 65536.0 + 0.5);
    return ((f * 8) - c) >>> 3;
  endfunction

  function automatic real idealMant(input int f);
    return ($pow(2.0, real'(f) / 8192.0) - 1.0) * 8192.0;
  endfunction

  // Reference model, compared on every clock.
  always @(negedge clk) begin
    pend_t p;
    real   r;
    real   d;
    if (monitorOn) begin
      negCount++;
      if (pendQ.size() > 0 && pendQ[0].due == negCount) begin
        p = pendQ.pop_front();
        report(outValid === 1'b1, "R2 R7", "result strobe", int'(outValid), 1);
        report(int'(outExp) == p.expV, "R1", "exponent", int'(outExp), p.expV);
        if ((p.frac & 127) == 0) begin
          report(int'(outMant) == exactMant(p.frac), "R3", "sample mantissa",
                 int'(outMant), exactMant(p.frac));
        end else begin
          r = idealMant(p.frac);
          d = real'(outMant) - r;
          report((d <= 2.0) && (d >= -2.0), "R4", "interpolated mantissa",
                 int'(outMant), $rtoi(r + 0.5));
        end
        lastExp  = int'(outExp);
        lastMant = int'(outMant);
      end else begin
        report(outValid === 1'b0, "R2", "idle strobe", int'(outValid), 0);
        report(int'(outExp) == lastExp, "R5", "held exponent", int'(outExp), lastExp);
        report(int'(outMant) == lastMant, "R5", "held mantissa", int'(outMant), lastMant);
      end
    end
  end

  task automatic send(input int e, input int f);
    pend_t p;
    @(negedge clk);
    #1;
    inValid = 1'b1;
    inM = {EXP_W'(e), FRAC_W'(f)};
    p.due  = negCount + LAT;
    p.expV = e & 255;
    p.frac = f & 8191;
    pendQ.push_back(p);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      #1;
      inValid = 1'b0;
    end
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    logic [31:0] seed;
    seed = 32'h1234_5678;

    // R6: reset state
    repeat (4) @(negedge clk);
    report(outValid === 1'b0, "R6", "reset strobe", int'(outValid), 0);
    report(outExp === '0, "R6", "reset exponent", int'(outExp), 0);
    report(outMant === '0, "R6", "reset mantissa", int'(outMant), 0);
    #1;
    rstN = 1'b1;
    monitorOn = 1'b1;

    // Isolated requests: sample points (R3), endpoints, exponent extremes (R1, R5)
    send(0, 0);           idle(3);
    send(127, 0);         idle(2);
    send(128, 8191);      idle(4);
    send(3, 1);           idle(1);
    send(255, 4096 + 64); idle(3);
    send(200, 63 * 128);  idle(2);
    send(17, 33 * 128 + 127); idle(3);

    // Full sweep back to back: every segment, every offset (R3, R4, R7)
    for (int f = 0; f < 8192; f++) begin
      send((f & 255) ^ 8'hA5, f);
    end
    idle(3);

    // Random operands with random gaps (R2, R5)
    for (int k = 0; k < 400; k++) begin
      seed = seed * 32'd1103515245 + 32'd12345;
      send(int'(seed[31:24]), int'(seed[20:8]));
      if (seed[3:2] != 2'd0) idle(int'(seed[3:2]));
    end

    idle(LAT + 4);
    done = 1'b1;
    finishRun();
  end

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R2 watchdog: actual %0d pending expected %0d", pendQ.size(), 0);
      finishRun();
    end
  end

endmodule